// File: doc/BRIEF.md
# Predicated Vector Element Issue Sequencer

This block walks one vector operation element by element and decides, for each element position, whether the external datapath writes its result, writes zero, or does nothing. It holds two small predication tables, one for integer operations and one for floating-point operations. Each table is indexed by the destination register number. A table entry can point at an integer register that holds the element mask, can ask for that mask to be inverted, and can ask for masked-off elements to be zeroed rather than left untouched.

When an operation is accepted, the block looks up the entry and presents the predicate register number on a read port. In the same cycle it captures the returned mask, applying the inversion or the all-ones default. It then issues one element per cycle. For each element it gives the destination and source register indices: a vector operand uses the base register plus the element index, and a scalar operand keeps its base register. It also gives a write-result or write-zero strobe. A one-cycle done pulse closes the operation. A configuration port fills the tables. The arithmetic and any renaming of register numbers are done outside the block.

Top module: `pred_elem_seq`

## Requirements
- R1: After reset the block is idle: `busy`, `done`, `iss_we` and `iss_zero` are 0, and every table entry in both tables is disabled.
- R2: `op_fp`=0 selects the integer table and `op_fp`=1 selects the floating-point table. The entry used is the one stored under key `rd` in the selected table. A write with `cfg_fp`=b and `cfg_key`=k replaces only entry k of table b.
- R3: If the selected entry is disabled, every element index is active, whatever `pred_rdata` holds.
- R4: If the selected entry is enabled, `pred_raddr` equals the entry's predicate register index while `start` is presented. The mask is the `pred_rdata` sampled on the accepting clock edge, and element i is active when bit i of that mask is 1.
- R5: If the entry is enabled and its invert flag is set, the bitwise complement of `pred_rdata` is used as the mask.
- R6: Elements are issued in the order 0, 1, …, vl−1, one per cycle, starting in the cycle after the accepting edge, with `busy`=1 and `iss_idx`=i. A `vl` above 32 is treated as 32.
- R7: For element i, a vector operand's index is (base + i) mod 32 and a scalar operand's index is its base. This rule applies separately to destination (`d_vec`), source 1 (`s1_vec`) and source 2 (`s2_vec`).
- R8: An active element raises `iss_we`. An inactive element raises `iss_zero` if the entry's zeroing flag is set, and raises neither strobe otherwise. The two strobes are never high together.
- R9: `done` is 1 for exactly one cycle: the cycle after the last element, or the cycle after the accepting edge when `vl`=0. In that cycle `busy`=0. With `vl`=0 no strobe is ever raised.
- R10: The mask, zeroing flag and operand fields are captured at acceptance. Table writes made during an operation change only later operations.
- R11: `start` is accepted only while `busy`=0. A `start` during an operation has no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Table write strobe |
| cfg_fp | input | 1 | Table select for the write (1 = floating-point) |
| cfg_key | input | 5 | Destination register key being written |
| cfg_en | input | 1 | Entry enable |
| cfg_inv | input | 1 | Entry invert flag |
| cfg_zero | input | 1 | Entry zeroing flag |
| cfg_pidx | input | 5 | Predicate register index of the entry |
| start | input | 1 | Operation request |
| op_fp | input | 1 | Operation type (1 = floating-point) |
| vl | input | 6 | Vector length |
| rd | input | 5 | Destination base register, also the table key |
| rs1 | input | 5 | Source 1 base register |
| rs2 | input | 5 | Source 2 base register |
| d_vec | input | 1 | Destination is a vector |
| s1_vec | input | 1 | Source 1 is a vector |
| s2_vec | input | 1 | Source 2 is a vector |
| pred_raddr | output | 5 | Integer register number of the predicate |
| pred_rdata | input | 32 | Contents of that register, returned combinationally |
| busy | output | 1 | An operation is being issued |
| done | output | 1 | One-cycle end-of-operation pulse |
| iss_we | output | 1 | Write the datapath result for this element |
| iss_zero | output | 1 | Write zero for this element |
| iss_idx | output | 5 | Element index |
| iss_rd | output | 5 | Destination register for this element |
| iss_rs1 | output | 5 | Source 1 register for this element |
| iss_rs2 | output | 5 | Source 2 register for this element |

## Verification
The embedded properties assume that `pred_rdata` is a combinational function of `pred_raddr` that settles within the cycle. They also assume that `start` may rise at any time, including while busy, and that the design itself does the filtering. The bench models the register file as a fixed array driven from `pred_raddr`. It changes inputs only on the falling edge, and it deliberately raises `start` and table writes during operations so that the filtering is exercised. Lengths sweep over 0, 1, the 32 limit, values above it, and index wrap past register 31.

// File: rtl/pred_seq_pkg.sv
package pred_seq_pkg;

  // control bits of one predication table entry
  typedef struct packed {
    logic en;
    logic inv;
    logic zero;
  } pflags_t;

  // per-element decision
  typedef enum logic [1:0] {
    ACT_SKIP  = 2'd0,
    ACT_WRITE = 2'd1,
    ACT_ZERO  = 2'd2
  } elem_act_e;

endpackage

// File: rtl/pred_table.sv
module pred_table
  import pred_seq_pkg::*;
#(
  parameter int NREG   = 32,
  parameter int RIDX_W = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_fp,
  input  logic [RIDX_W-1:0] wr_key,
  input  pflags_t           wr_flags,
  input  logic [RIDX_W-1:0] wr_pidx,
  input  logic              rd_fp,
  input  logic [RIDX_W-1:0] rd_key,
  output pflags_t           rd_flags,
  output logic [RIDX_W-1:0] rd_pidx
);

  localparam int NBANK = 2;

  pflags_t           bank_fl [NBANK];
  logic [RIDX_W-1:0] bank_px [NBANK];

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    pflags_t           fl_q [NREG];
    logic [RIDX_W-1:0] px_q [NREG];
    logic              bank_we;

    assign bank_we = wr_en && (wr_fp == 1'(b));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int k = 0; k < NREG; k++) begin
          fl_q[k] <= '0;
          px_q[k] <= '0;
        end
      end else if (bank_we) begin
        fl_q[wr_key] <= wr_flags;
        px_q[wr_key] <= wr_pidx;
      end
    end

    assign bank_fl[b] = fl_q[rd_key];
    assign bank_px[b] = px_q[rd_key];
  end

  always_comb begin
    rd_flags = rd_fp ? bank_fl[1] : bank_fl[0];
    rd_pidx  = rd_fp ? bank_px[1] : bank_px[0];
  end

endmodule

// File: rtl/pred_mask.sv
module pred_mask
  import pred_seq_pkg::*;
#(
  parameter int PRED_W = 32
) (
  input  pflags_t           flags,
  input  logic [PRED_W-1:0] raw,
  output logic [PRED_W-1:0] mask
);

  always_comb begin
    if (!flags.en)      mask = '1;
    else if (flags.inv) mask = ~raw;
    else                mask = raw;
  end

endmodule

// File: rtl/elem_issue.sv
module elem_issue
  import pred_seq_pkg::*;
#(
  parameter int NREG   = 32,
  parameter int PRED_W = 32,
  parameter int RIDX_W = $clog2(NREG),
  parameter int VL_W   = $clog2(PRED_W + 1),
  parameter int PIDX_W = $clog2(PRED_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [VL_W-1:0]   vl,
  input  logic [PRED_W-1:0] mask,
  input  logic              zero_en,
  input  logic [RIDX_W-1:0] rd,
  input  logic [RIDX_W-1:0] rs1,
  input  logic [RIDX_W-1:0] rs2,
  input  logic              d_vec,
  input  logic              s1_vec,
  input  logic              s2_vec,
  output logic              busy,
  output logic              done,
  output logic              iss_we,
  output logic              iss_zero,
  output logic [PIDX_W-1:0] iss_idx,
  output logic [RIDX_W-1:0] iss_rd,
  output logic [RIDX_W-1:0] iss_rs1,
  output logic [RIDX_W-1:0] iss_rs2
);

  localparam logic [VL_W-1:0] VL_MAX = VL_W'(PRED_W);

  // state
  logic              busy_q, busy_d;
  logic              done_q, done_d;
  logic [PIDX_W-1:0] idx_q, idx_d;
  logic [PIDX_W-1:0] last_q, last_d;
  logic [PRED_W-1:0] mask_q;
  logic              zero_q;
  logic [RIDX_W-1:0] rd_q, rs1_q, rs2_q;
  logic              dv_q, s1v_q, s2v_q;

  logic              accept;
  logic [VL_W-1:0]   vl_eff;
  logic              at_last;
  elem_act_e         act;

  // next state
  always_comb begin
    accept  = start && !busy_q;
    vl_eff  = (vl > VL_MAX) ? VL_MAX : vl;
    at_last = (idx_q == last_q);
    busy_d  = busy_q;
    done_d  = 1'b0;
    idx_d   = idx_q;
    last_d  = last_q;
    if (accept) begin
      busy_d = (vl_eff != '0);
      done_d = (vl_eff == '0);
      idx_d  = '0;
      last_d = PIDX_W'(vl_eff - VL_W'(1));
    end else if (busy_q) begin
      if (at_last) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end else begin
        idx_d = idx_q + PIDX_W'(1);
      end
    end
  end

  // sequencing registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      idx_q  <= '0;
      last_q <= '0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      idx_q  <= idx_d;
      last_q <= last_d;
    end
  end

  // operation capture, enabled on acceptance only
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      zero_q <= 1'b0;
      rd_q   <= '0;
      rs1_q  <= '0;
      rs2_q  <= '0;
      dv_q   <= 1'b0;
      s1v_q  <= 1'b0;
      s2v_q  <= 1'b0;
    end else if (accept) begin
      mask_q <= mask;
      zero_q <= zero_en;
      rd_q   <= rd;
      rs1_q  <= rs1;
      rs2_q  <= rs2;
      dv_q   <= d_vec;
      s1v_q  <= s1_vec;
      s2v_q  <= s2_vec;
    end
  end

  // per-element decision and indices
  always_comb begin
    if (!busy_q)             act = ACT_SKIP;
    else if (mask_q[idx_q])  act = ACT_WRITE;
    else if (zero_q)         act = ACT_ZERO;
    else                     act = ACT_SKIP;
  end

  assign busy     = busy_q;
  assign done     = done_q;
  assign iss_we   = (act == ACT_WRITE);
  assign iss_zero = (act == ACT_ZERO);
  assign iss_idx  = idx_q;
  assign iss_rd   = dv_q  ? rd_q  + RIDX_W'(idx_q) : rd_q;
  assign iss_rs1  = s1v_q ? rs1_q + RIDX_W'(idx_q) : rs1_q;
  assign iss_rs2  = s2v_q ? rs2_q + RIDX_W'(idx_q) : rs2_q;

  // R9
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy_q && done_q));

  // R6
  idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $past(busy_q)) |-> (idx_q == PIDX_W'($past(idx_q) + PIDX_W'(1))));

  // R9
  done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && at_last) |=> (done_q && !busy_q));

  // R11
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |=> $stable(mask_q));

  // R8
  we_zero_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(iss_we && iss_zero));

endmodule

// File: rtl/pred_elem_seq.sv
module pred_elem_seq
  import pred_seq_pkg::*;
#(
  parameter int NREG   = 32,
  parameter int PRED_W = 32,
  parameter int RIDX_W = $clog2(NREG),
  parameter int VL_W   = $clog2(PRED_W + 1),
  parameter int PIDX_W = $clog2(PRED_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_fp,
  input  logic [RIDX_W-1:0] cfg_key,
  input  logic              cfg_en,
  input  logic              cfg_inv,
  input  logic              cfg_zero,
  input  logic [RIDX_W-1:0] cfg_pidx,
  input  logic              start,
  input  logic              op_fp,
  input  logic [VL_W-1:0]   vl,
  input  logic [RIDX_W-1:0] rd,
  input  logic [RIDX_W-1:0] rs1,
  input  logic [RIDX_W-1:0] rs2,
  input  logic              d_vec,
  input  logic              s1_vec,
  input  logic              s2_vec,
  output logic [RIDX_W-1:0] pred_raddr,
  input  logic [PRED_W-1:0] pred_rdata,
  output logic              busy,
  output logic              done,
  output logic              iss_we,
  output logic              iss_zero,
  output logic [PIDX_W-1:0] iss_idx,
  output logic [RIDX_W-1:0] iss_rd,
  output logic [RIDX_W-1:0] iss_rs1,
  output logic [RIDX_W-1:0] iss_rs2
);

  pflags_t           wr_flags;
  pflags_t           lk_flags;
  logic [RIDX_W-1:0] lk_pidx;
  logic [PRED_W-1:0] eff_mask;

  assign wr_flags   = '{en: cfg_en, inv: cfg_inv, zero: cfg_zero};
  assign pred_raddr = lk_pidx;

  pred_table #(.NREG(NREG), .RIDX_W(RIDX_W)) u_tab (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (cfg_we),
    .wr_fp    (cfg_fp),
    .wr_key   (cfg_key),
    .wr_flags (wr_flags),
    .wr_pidx  (cfg_pidx),
    .rd_fp    (op_fp),
    .rd_key   (rd),
    .rd_flags (lk_flags),
    .rd_pidx  (lk_pidx)
  );

  pred_mask #(.PRED_W(PRED_W)) u_mask (
    .flags (lk_flags),
    .raw   (pred_rdata),
    .mask  (eff_mask)
  );

  elem_issue #(
    .NREG(NREG), .PRED_W(PRED_W), .RIDX_W(RIDX_W), .VL_W(VL_W), .PIDX_W(PIDX_W)
  ) u_iss (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .vl       (vl),
    .mask     (eff_mask),
    .zero_en  (lk_flags.zero),
    .rd       (rd),
    .rs1      (rs1),
    .rs2      (rs2),
    .d_vec    (d_vec),
    .s1_vec   (s1_vec),
    .s2_vec   (s2_vec),
    .busy     (busy),
    .done     (done),
    .iss_we   (iss_we),
    .iss_zero (iss_zero),
    .iss_idx  (iss_idx),
    .iss_rd   (iss_rd),
    .iss_rs1  (iss_rs1),
    .iss_rs2  (iss_rs2)
  );

endmodule

// File: tb/pred_elem_seq_tb_top.sv
module pred_elem_seq_tb_top;

  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0, cfg_fp = 1'b0, cfg_en = 1'b0, cfg_inv = 1'b0, cfg_zero = 1'b0;
  logic [4:0] cfg_key = '0, cfg_pidx = '0;
  logic       start = 1'b0, op_fp = 1'b0, d_vec = 1'b0, s1_vec = 1'b0, s2_vec = 1'b0;
  logic [5:0] vl = '0;
  logic [4:0] rd = '0, rs1 = '0, rs2 = '0;
  logic [4:0] pred_raddr;
  logic [31:0] pred_rdata;
  logic       busy, done, iss_we, iss_zero;
  logic [4:0] iss_idx, iss_rd, iss_rs1, iss_rs2;

  int total = 0;
  int bad = 0;

  // bench model of tables: {en,inv,zero}, pidx
  logic [2:0] m_fl [2][32];
  logic [4:0] m_px [2][32];
  logic [31:0] rf [32];

  always #(CLK_P/2) clk = ~clk;

  assign pred_rdata = rf[pred_raddr];

  pred_elem_seq dut_i (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_fp(cfg_fp), .cfg_key(cfg_key), .cfg_en(cfg_en),
    .cfg_inv(cfg_inv), .cfg_zero(cfg_zero), .cfg_pidx(cfg_pidx),
    .start(start), .op_fp(op_fp), .vl(vl), .rd(rd), .rs1(rs1), .rs2(rs2),
    .d_vec(d_vec), .s1_vec(s1_vec), .s2_vec(s2_vec),
    .pred_raddr(pred_raddr), .pred_rdata(pred_rdata),
    .busy(busy), .done(done), .iss_we(iss_we), .iss_zero(iss_zero),
    .iss_idx(iss_idx), .iss_rd(iss_rd), .iss_rs1(iss_rs1), .iss_rs2(iss_rs2)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cfg_write(input bit fp, input logic [4:0] key, input bit en,
                           input bit inv, input bit zr, input logic [4:0] px);
    @(negedge clk);
    cfg_we = 1'b1; cfg_fp = fp; cfg_key = key; cfg_en = en; cfg_inv = inv;
    cfg_zero = zr; cfg_pidx = px;
    m_fl[fp][key] = {en, inv, zr};
    m_px[fp][key] = px;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // disturb: 1 = start during op, 2 = table write to own entry during op
  task automatic run_op(input bit fp, input int vlen, input logic [4:0] d,
                        input logic [4:0] a, input logic [4:0] b,
                        input bit dv, input bit av, input bit bv, input int disturb);
    logic [31:0] m;
    logic [2:0]  fl;
    int          n;
    fl = m_fl[fp][d];
    m  = !fl[2] ? 32'hFFFF_FFFF : (fl[1] ? ~rf[m_px[fp][d]] : rf[m_px[fp][d]]);
    n  = (vlen > 32) ? 32 : vlen;
    @(negedge clk);
    start = 1'b1; op_fp = fp; vl = 6'(vlen); rd = d; rs1 = a; rs2 = b;
    d_vec = dv; s1_vec = av; s2_vec = bv;
    #1;
    if (fl[2]) check(pred_raddr == m_px[fp][d], "R4 pred_raddr", pred_raddr, m_px[fp][d]);
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < n; i++) begin
      logic ex_we, ex_z;
      logic [4:0] ed, ea, eb;
      ex_we = m[i];
      ex_z  = !m[i] && fl[0];
      ed = dv ? 5'(d + i) : d;
      ea = av ? 5'(a + i) : a;
      eb = bv ? 5'(b + i) : b;
      check(busy && !done, "R6 busy during element", {busy, done}, 2'b10);
      check(iss_idx == 5'(i), "R6 element order", iss_idx, i);
      check(iss_we == ex_we, "R3/R4/R5 write strobe", iss_we, ex_we);
      check(iss_zero == ex_z, "R8 zero strobe", iss_zero, ex_z);
      check({iss_rd, iss_rs1, iss_rs2} == {ed, ea, eb}, "R7 operand indices",
            {iss_rd, iss_rs1, iss_rs2}, {ed, ea, eb});
      if (i == 1 && disturb == 1) begin
        start = 1'b1; vl = 6'd3; rd = 5'(d + 1); d_vec = !dv;   // R11
      end
      if (i == 1 && disturb == 2) begin
        cfg_we = 1'b1; cfg_fp = fp; cfg_key = d; cfg_en = 1'b1;  // R10
        cfg_inv = !fl[1]; cfg_zero = !fl[0]; cfg_pidx = 5'(m_px[fp][d] + 3);
        m_fl[fp][d] = {1'b1, !fl[1], !fl[0]};
        m_px[fp][d] = 5'(m_px[fp][d] + 3);
      end
      @(negedge clk);
      start = 1'b0; cfg_we = 1'b0;
    end
    check(done && !busy, "R9 done after last", {done, busy}, 2'b10);
    check(!iss_we && !iss_zero, "R9 no strobe at done", {iss_we, iss_zero}, 0);
    @(negedge clk);
    check(!done && !busy, "R9 done single cycle", {done, busy}, 2'b00);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int k = 0; k < 32; k++) begin
      rf[k] = (32'h9E37_79B9 * (k + 1)) ^ (32'(k) << 7);
      m_fl[0][k] = '0; m_fl[1][k] = '0; m_px[0][k] = '0; m_px[1][k] = '0;
    end
    rf[0] = 32'h0; rf[1] = 32'hFFFF_FFFF;
    repeat (3) @(negedge clk);
    // R1 reset state
    check({busy, done, iss_we, iss_zero} == 4'b0, "R1 reset outputs",
          {busy, done, iss_we, iss_zero}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check({busy, done, iss_we, iss_zero} == 4'b0, "R1 idle after release",
          {busy, done, iss_we, iss_zero}, 0);
    // R1/R3: entries disabled after reset -> all active
    run_op(1'b0, 8, 5'd4, 5'd10, 5'd20, 1, 1, 0, 0);
    run_op(1'b1, 5, 5'd4, 5'd2, 5'd3, 0, 0, 1, 0);

    // sweep of flag combinations over both tables
    for (int fp = 0; fp < 2; fp++) begin
      for (int c = 0; c < 8; c++) begin
        int lens [8] = '{0, 1, 7, 32, 40, 13, 31, 2};
        logic [4:0] key;
        key = 5'(c * 3 + fp * 7 + 1);
        cfg_write(fp[0], key, c[2], c[1], c[0], 5'(c * 5 + fp + 2));
        run_op(fp[0], lens[c], key, 5'(c + 26), 5'(c * 4), c[0], c[1], c[2], 0);
      end
    end

    // R2: same key, different content in each table
    cfg_write(1'b0, 5'd9, 1, 0, 1, 5'd0);   // int: mask all zero, zeroing
    cfg_write(1'b1, 5'd9, 1, 1, 0, 5'd0);   // fp: inverted zero -> all active
    run_op(1'b0, 6, 5'd9, 5'd1, 5'd2, 1, 0, 0, 0);
    run_op(1'b1, 6, 5'd9, 5'd1, 5'd2, 1, 0, 0, 0);
    // R2: writing fp entry 9 left int entry 9 intact
    run_op(1'b0, 3, 5'd9, 5'd1, 5'd2, 0, 0, 0, 0);

    // R7: index wrap past register 31
    cfg_write(1'b0, 5'd30, 1, 0, 0, 5'd1);
    run_op(1'b0, 7, 5'd30, 5'd29, 5'd31, 1, 1, 1, 0);

    // R11: start during an operation
    cfg_write(1'b0, 5'd12, 1, 0, 1, 5'd17);
    run_op(1'b0, 9, 5'd12, 5'd3, 5'd5, 1, 1, 0, 1);
    // R10: table write during an operation, then next op uses it
    run_op(1'b0, 10, 5'd12, 5'd3, 5'd5, 1, 0, 1, 2);
    run_op(1'b0, 10, 5'd12, 5'd3, 5'd5, 1, 0, 1, 0);

    // R9: zero length right after another zero length
    run_op(1'b1, 0, 5'd9, 5'd0, 5'd0, 1, 1, 1, 0);
    run_op(1'b1, 0, 5'd9, 5'd0, 5'd0, 1, 1, 1, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule